// File: doc/BRIEF.md
# External Bus Wait-State Controller

This block paces accesses on an external memory bus whose address space is split into eight areas. It keeps a 16-bit software-visible timing register with a wait field for areas 3, 4, 5 and 6. On each bus cycle it reads the target area from three upper address bits and loads that area's programmed wait count. It then holds the cycle for that many clocks before it returns a single-cycle ready pulse.

Whenever the loaded count is non-zero, the cycle can be stretched further by an external active-low wait input. The input is sampled on the final programmed wait clock, and each low sample adds one clock. A count of zero completes the cycle without looking at the pin.

Area 3 can be flagged as synchronous DRAM. In that case its two-bit field gives a CAS latency, which is presented to the access sequencer, and the access itself takes no wait clocks here. Areas 5 and 6 each take a fourth, high-order count bit from a separate configuration input. Areas 0, 1, 2 and 7 use a fixed count set by a parameter.

Top module: `bus_wait_ctrl`

## Requirements
- R1: The timing register reads back bits 15:5 as last written. Bits 4:0 always read 0 and ignore writes. After reset the register reads 16'hFFE0, so every implemented bit is 1.
- R2: An access to area 6 (address bits 28:26 = 6) waits {xbit[1], reg[15:13]} clocks. An access to area 5 (= 5) waits {xbit[0], reg[12:10]} clocks.
- R3: An access to area 4 waits reg[9:7] clocks (0 to 7).
- R4: An access to area 3 with the DRAM flag low waits reg[6:5] clocks (0 to 3).
- R5: When the loaded count is zero, the wait input is ignored. When the count is non-zero, the wait input is honoured.
- R6: If the request is sampled at clock edge E, ready is high for exactly one cycle, starting at edge E+N, where N is the wait count (ready follows E itself when N is 0).
- R7: While the wait input is low at the edge that ends the last programmed wait clock, one more wait clock is added each time. Ready follows the first edge at which the input is sampled high.
- R8: cas_lat always shows the area 3 field as a CAS latency: code 00→1, 01→1, 10→2, 11→3. With the DRAM flag high, an area 3 access completes with zero wait clocks and ignores the wait input.
- R9: Areas 0, 1, 2 and 7 wait DFLT_WAIT clocks (default 2), with the wait input honoured if that value is non-zero.
- R10: A request that arrives while an access is still waiting is ignored. It produces no extra ready, and it does not change the count in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Timing register write strobe |
| reg_wdata | input | 16 | Timing register write data |
| reg_rdata | output | 16 | Timing register read data |
| xbit | input | 2 | High-order count bit for area 5 (bit 0) and area 6 (bit 1) |
| dram_a3 | input | 1 | Area 3 holds synchronous DRAM |
| req | input | 1 | Start-of-cycle pulse |
| addr_area | input | 3 | Address bits 28:26 of the bus cycle |
| wait_n | input | 1 | External wait, active low |
| ready | output | 1 | One-cycle end-of-cycle pulse |
| cas_lat | output | 2 | CAS latency for area 3 (1 to 3) |

## Verification
The bench uses the default parameters: a 4-bit count and DFLT_WAIT of 2. With these, the widest count the block can load, 15, is reached through area 6 with its high-order bit set, so a 15- and 16-clock access stays well inside the run. The default area's count of 2 makes it possible to tell the fixed-count areas apart from the register-driven ones and from the zero-count path. The four-bit width also lets the overlapping-request test arrive mid-count without the count wrapping.

// File: rtl/bwc_pkg.sv
package bwc_pkg;
  localparam int REG_W = 16;
  localparam int CNT_W = 4;
  localparam logic [REG_W-1:0] CFG_MASK  = 16'hFFE0;
  localparam logic [REG_W-1:0] CFG_RESET = 16'hFFE0;

  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } seq_state_t;

  function automatic logic [1:0] cas_of(input logic [1:0] code);
    return (code == 2'b00) ? 2'd1 : code;
  endfunction
endpackage

// File: rtl/bwc_cfg_reg.sv
module bwc_cfg_reg
  import bwc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] q
);
  logic [REG_W-1:0] q_d;

  always_comb begin
    q_d = q;
    if (we) q_d = wdata & CFG_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= CFG_RESET;
    else        q <= q_d;
  end
endmodule

// File: rtl/bwc_area_lookup.sv
module bwc_area_lookup
  import bwc_pkg::*;
#(
  parameter int DFLT_WAIT = 2
) (
  input  logic [2:0]       area,
  input  logic [10:0]      fields,   // register bits 15:5
  input  logic [1:0]       xbit,
  input  logic             dram_a3,
  output logic [CNT_W-1:0] count,
  output logic             honour,
  output logic [1:0]       cas_lat
);
  localparam logic [CNT_W-1:0] DFLT_CNT = CNT_W'(DFLT_WAIT);

  logic [2:0] f_a6, f_a5, f_a4;
  logic [1:0] f_a3;

  assign f_a6 = fields[10:8];
  assign f_a5 = fields[7:5];
  assign f_a4 = fields[4:2];
  assign f_a3 = fields[1:0];

  assign cas_lat = cas_of(f_a3);

  always_comb begin
    count  = DFLT_CNT;
    honour = (DFLT_CNT != '0);
    unique case (area)
      3'd6: begin
        count  = {xbit[1], f_a6};
        honour = (count != '0);
      end
      3'd5: begin
        count  = {xbit[0], f_a5};
        honour = (count != '0);
      end
      3'd4: begin
        count  = {1'b0, f_a4};
        honour = (count != '0);
      end
      3'd3: begin
        if (dram_a3) begin
          count  = '0;
          honour = 1'b0;
        end else begin
          count  = {2'b00, f_a3};
          honour = (count != '0);
        end
      end
      default: begin
        count  = DFLT_CNT;
        honour = (DFLT_CNT != '0);
      end
    endcase
  end
endmodule

// File: rtl/bwc_wait_seq.sv
module bwc_wait_seq
  import bwc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic [CNT_W-1:0] count_in,
  input  logic             honour_in,
  input  logic             wait_n,
  output logic             ready
);
  seq_state_t       st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             hon_q, hon_d;
  logic             rdy_d;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    hon_d = hon_q;
    rdy_d = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (req) begin
          if (count_in == '0) begin
            rdy_d = 1'b1;
          end else begin
            st_d  = ST_WAIT;
            cnt_d = count_in;
            hon_d = honour_in;
          end
        end
      end
      ST_WAIT: begin
        if (cnt_q > CNT_W'(1)) begin
          cnt_d = cnt_q - CNT_W'(1);
        end else if (!(hon_q && !wait_n)) begin
          rdy_d = 1'b1;
          st_d  = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
      hon_q <= 1'b0;
      ready <= 1'b0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      hon_q <= hon_d;
      ready <= rdy_d;
    end
  end
endmodule

// File: rtl/bus_wait_ctrl.sv
module bus_wait_ctrl
  import bwc_pkg::*;
#(
  parameter int DFLT_WAIT = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [15:0] reg_wdata,
  output logic [15:0] reg_rdata,
  input  logic [1:0]  xbit,
  input  logic        dram_a3,
  input  logic        req,
  input  logic [2:0]  addr_area,
  input  logic        wait_n,
  output logic        ready,
  output logic [1:0]  cas_lat
);
  logic [REG_W-1:0] cfg_q;
  logic [CNT_W-1:0] sel_count;
  logic             sel_honour;

  bwc_cfg_reg u_reg (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (reg_we),
    .wdata (reg_wdata),
    .q     (cfg_q)
  );

  assign reg_rdata = cfg_q;

  bwc_area_lookup #(.DFLT_WAIT(DFLT_WAIT)) u_lookup (
    .area    (addr_area),
    .fields  (cfg_q[15:5]),
    .xbit    (xbit),
    .dram_a3 (dram_a3),
    .count   (sel_count),
    .honour  (sel_honour),
    .cas_lat (cas_lat)
  );

  bwc_wait_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .req       (req),
    .count_in  (sel_count),
    .honour_in (sel_honour),
    .wait_n    (wait_n),
    .ready     (ready)
  );
endmodule

// File: rtl/bwc_checker.sv
module bwc_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        req,
  input logic        ready,
  input logic        reg_we,
  input logic [15:0] reg_rdata,
  input logic [1:0]  cas_lat
);
  logic open_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     open_q <= 1'b0;
    else if (ready) open_q <= req;
    else            open_q <= open_q | req;
  end

  // R1: low bits never hold data
  a_r1_low_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[4:0] == 5'd0);

  // R1: register holds its value without a write
  a_r1_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_we |=> $stable(reg_rdata));

  // R6: ready lasts one cycle unless a new access is started
  a_r6_ready_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    ready && !req |=> !ready);

  // R10: ready only closes an outstanding access
  a_r10_ready_owned: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> open_q);

  // R8: CAS latency is never zero
  a_r8_cas_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    cas_lat != 2'd0);
endmodule

bind bus_wait_ctrl bwc_checker u_bwc_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req       (req),
  .ready     (ready),
  .reg_we    (reg_we),
  .reg_rdata (reg_rdata),
  .cas_lat   (cas_lat)
);

// File: tb/bus_wait_ctrl_bench.sv
`timescale 1ns/1ps
module bus_wait_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_we;
  logic [15:0] reg_wdata;
  logic [15:0] reg_rdata;
  logic [1:0]  xbit;
  logic        dram_a3;
  logic        req;
  logic [2:0]  addr_area;
  logic        wait_n;
  logic        ready;
  logic [1:0]  cas_lat;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  bus_wait_ctrl u_bus_wait_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .xbit(xbit), .dram_a3(dram_a3), .req(req),
    .addr_area(addr_area), .wait_n(wait_n), .ready(ready), .cas_lat(cas_lat)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] cfg(input int a6, input int a5, input int a4, input int a3);
    return {a6[2:0], a5[2:0], a4[2:0], a3[1:0], 5'b0};
  endfunction

  task automatic wr(input logic [15:0] d);
    @(negedge clk); reg_we = 1'b1; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  // hold: wait_n is driven high from the negedge numbered hold onward
  task automatic access(input logic [2:0] area, input int hold, input int exp, input string tag);
    int c;
    @(negedge clk); req = 1'b1; addr_area = area; wait_n = (-1 >= hold);
    @(negedge clk); req = 1'b0; c = 0;
    while (!ready && c < 64) begin
      wait_n = (c >= hold);
      @(negedge clk); c++;
    end
    check({tag, " latency"}, c, exp);
    @(negedge clk);
    check({tag, " pulse width"}, int'(ready), 0);
    wait_n = 1'b1;
  endtask

  task automatic t_reset();
    check("R1 reset rdata", int'(reg_rdata), 16'hFFE0);
    check("R6 reset ready", int'(ready), 0);
    check("R8 reset cas", int'(cas_lat), 3);
    access(3'd3, -1, 3, "R4 reset area3");
    access(3'd4, -1, 7, "R3 reset area4");
  endtask

  task automatic t_reg();
    wr(16'hFFFF);
    @(negedge clk); check("R1 write ones", int'(reg_rdata), 16'hFFE0);
    wr(16'h0000);
    @(negedge clk); check("R1 write zero", int'(reg_rdata), 0);
    wr(16'hA5A5);
    @(negedge clk); check("R1 pattern", int'(reg_rdata), 16'hA5A0);
  endtask

  task automatic t_area3();
    wr(cfg(0, 0, 0, 0));
    access(3'd3, 50, 0, "R5 area3 code0 wait ignored");
    for (int k = 1; k < 4; k++) begin
      wr(cfg(0, 0, 0, k));
      access(3'd3, -1, k, "R4 area3 count");
    end
    wr(cfg(0, 0, 0, 2));
    access(3'd3, 2 + 2 - 1, 4, "R7 area3 stall2");
  endtask

  task automatic t_area4();
    wr(cfg(0, 0, 5, 0));
    access(3'd4, -1, 5, "R3 area4 five");
    access(3'd4, 5 + 3 - 1, 8, "R7 area4 stall3");
    wr(cfg(0, 0, 0, 0));
    access(3'd4, 50, 0, "R5 area4 zero ignores wait");
  endtask

  task automatic t_area56();
    wr(cfg(7, 3, 0, 0));
    xbit = 2'b01;
    access(3'd5, -1, 11, "R2 area5 with xbit");
    xbit = 2'b10;
    access(3'd5, -1, 3, "R2 area5 no xbit");
    access(3'd6, -1, 15, "R2 area6 max");
    access(3'd6, 15, 16, "R7 area6 stall1");
    xbit = 2'b00;
    access(3'd6, -1, 7, "R2 area6 no xbit");
  endtask

  task automatic t_dram();
    dram_a3 = 1'b1;
    for (int k = 0; k < 4; k++) begin
      wr(cfg(0, 0, 0, k));
      @(negedge clk);
      check("R8 cas map", int'(cas_lat), (k == 0) ? 1 : k);
    end
    access(3'd3, 50, 0, "R8 dram access no wait");
    dram_a3 = 1'b0;
    access(3'd3, -1, 3, "R4 area3 ordinary again");
  endtask

  task automatic t_default();
    access(3'd0, -1, 2, "R9 area0");
    access(3'd7, -1, 2, "R9 area7");
    access(3'd1, 2 + 1 - 1, 3, "R9 area1 stall1");
  endtask

  task automatic t_busy();
    int c;
    int extra;
    wr(cfg(0, 0, 5, 0));
    @(negedge clk); req = 1'b1; addr_area = 3'd4;
    @(negedge clk); req = 1'b0; c = 0;
    while (!ready && c < 64) begin
      if (c == 2) begin req = 1'b1; addr_area = 3'd0; end
      else req = 1'b0;
      @(negedge clk); c++;
    end
    req = 1'b0;
    check("R10 busy latency", c, 5);
    extra = 0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (ready) extra++;
    end
    check("R10 no extra ready", extra, 0);
  endtask

  initial begin
    rst_n = 1'b0; reg_we = 1'b0; reg_wdata = '0; xbit = 2'b00;
    dram_a3 = 1'b0; req = 1'b0; addr_area = 3'd0; wait_n = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_reg();
    t_area3();
    t_area4();
    t_area56();
    t_dram();
    t_default();
    t_busy();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule